// File: doc/BRIEF.md
# Asymmetric Instruction Decode Allocator

This block sits between an instruction fetch buffer and the micro-op queue. Each cycle it looks at a window of up to three already length-marked instructions. Each instruction carries a tag and the number of micro-ops it expands into. The block steers them, strictly in program order, onto three decoder slots of unequal ability. Slot 0 is a general decoder that can expand one instruction into as many as four micro-ops. Slots 1 and 2 only accept instructions that expand into exactly one micro-op. An instruction that needs more than four micro-ops uses slot 0 for its first four. A sequencer then emits the rest over the following cycles, four at a time. While the sequencer runs, the group is broken and no further instructions are taken.

The combinational take count tells the fetch buffer how many window entries were accepted in the current cycle. The registered micro-op bundle appears on the next cycle. The bundle has six lanes. Lanes 0 to 3 belong to slot 0 and to the sequencer. Lane 4 belongs to slot 1 and lane 5 to slot 2. Each micro-op carries one operation and two source and one destination register numbers, produced by a small synthetic lookup. A downstream stall freezes the block. A flush abandons any sequencing in progress.

Top module: `asym_decode_alloc`

## Requirements
- R1: After reset every lane of the bundle is invalid, and with an empty window the take count is 0.
- R2: A valid instruction in window position 0 with n micro-ops (1 to 4) is always taken. Lanes 0 to n-1 of the next cycle's bundle carry its micro-op indices 0 to n-1, and lanes n to 3 are invalid.
- R3: Position 1 is taken into lane 4 only when position 0 is taken with no sequencing and position 1 is valid with exactly one micro-op. Position 2 is taken into lane 5 only when position 1 was taken and position 2 is valid with exactly one micro-op. The take count equals the number of positions taken.
- R4: Allocation stops at the first position that is invalid or needs more than one micro-op in a simple slot. Nothing after that position is taken. An invalid position 0 gives a take count of 0 and an all-invalid bundle.
- R5: An instruction in position 0 with more than four micro-ops is taken alone (take count 1), and its indices 0 to 3 fill lanes 0 to 3. On each following cycle the take count is 0, and lanes 0 to min(4,left)-1 carry the next indices in increasing order. This continues until all of its micro-ops are emitted. The window is then allocated again.
- R6: The micro-op with index k of an instruction with 8-bit tag t has: operation (t+k) mod 256, source A (t xor k) mod 16, source B ((t>>4)+k) mod 16, and destination (t+3k) mod 16.
- R7: While stall is high and flush is low, the take count is 0, the bundle holds its values, and sequencer progress is frozen.
- R8: While flush is high the take count is 0. On the next cycle the bundle is all invalid, and any sequencing in progress is abandoned. Flush takes priority over stall.
- R9: The take count responds to the window within the same cycle. The bundle that results from that decision appears after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Abandon sequencing and clear the bundle |
| stall | input | 1 | Downstream hold |
| win_vld | input | 3 | Valid bit per window position, bit 0 oldest |
| win_cnt | input | 15 | Micro-op count per position, 5 bits each, position i at bits [5i+4:5i] |
| win_tag | input | 24 | Instruction tag per position, 8 bits each, position i at bits [8i+7:8i] |
| take_cnt | output | 2 | Window entries accepted this cycle |
| uop_vld | output | 6 | Valid bit per bundle lane |
| uop_op | output | 48 | Operation per lane, 8 bits each, lane i at bits [8i+7:8i] |
| uop_sa | output | 24 | Source A per lane, 4 bits each |
| uop_sb | output | 24 | Source B per lane, 4 bits each |
| uop_dst | output | 24 | Destination per lane, 4 bits each |

## Verification
The take count is combinational, so the bench reads it one nanosecond after driving the window, well before the next rising edge. The bundle passes through one register. It is read at the falling edge that follows the capturing rising edge. For a long instruction, each later sequencer cycle is one more edge, checked the same way. The sweep runs every mix of invalid, single, two, four, five and nine micro-op entries across all three positions. A reference model in the bench advances its expected sequencer state one step per edge, alongside the stall and flush scenarios.

// File: rtl/ada_pkg.sv
package ada_pkg;
  localparam int OP_W  = 8;
  localparam int REG_W = 4;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [REG_W-1:0] src_a;
    logic [REG_W-1:0] src_b;
    logic [REG_W-1:0] dst;
  } uop_t;
endpackage

// File: rtl/ada_uop_gen.sv
// Synthetic payload lookup: one micro-op from instruction tag and index.
module ada_uop_gen
  import ada_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [OP_W-1:0]  tag,
  input  logic [CNT_W-1:0] idx,
  output uop_t             uop
);
  logic [OP_W-1:0] k;
  assign k         = OP_W'(idx);
  assign uop.op    = tag + k;
  assign uop.src_a = REG_W'(tag ^ k);
  assign uop.src_b = REG_W'((tag >> REG_W) + k);
  assign uop.dst   = REG_W'(tag + k + k + k);
endmodule

// File: rtl/ada_seq.sv
// Multi-cycle expander for instructions longer than the general slot.
module ada_seq
  import ada_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int GEN_UOPS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             advance,
  input  logic             start,
  input  logic [OP_W-1:0]  start_tag,
  input  logic [CNT_W-1:0] start_left,
  output logic             active,
  output logic [OP_W-1:0]  seq_tag,
  output logic [CNT_W-1:0] seq_idx,
  output logic [CNT_W-1:0] seq_left
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(GEN_UOPS);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      seq_left <= '0;
      seq_idx  <= '0;
      seq_tag  <= '0;
    end else if (advance) begin
      if (start) begin
        seq_tag  <= start_tag;
        seq_idx  <= STEP;
        seq_left <= start_left;
      end else if (seq_left != '0) begin
        seq_idx  <= seq_idx + STEP;
        seq_left <= (seq_left > STEP) ? seq_left - STEP : '0;
      end
    end
  end

  assign active = (seq_left != '0);

  // R5: every advancing sequencer cycle strictly reduces the remaining count
  assert_seq_drains_R5: assert property (@(posedge clk) disable iff (rst)
    active && advance && !flush && !start |=> seq_left < $past(seq_left));
  // R7: a frozen sequencer keeps its position
  assert_seq_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    !advance && !flush |=> $stable(seq_left) && $stable(seq_idx));
endmodule

// File: rtl/asym_decode_alloc.sv
module asym_decode_alloc
  import ada_pkg::*;
#(
  parameter int WIN      = 3,
  parameter int CNT_W    = 5,
  parameter int GEN_UOPS = 4,
  localparam int LANES   = GEN_UOPS + WIN - 1,
  localparam int TAKE_W  = $clog2(WIN + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic                   stall,
  input  logic [WIN-1:0]         win_vld,
  input  logic [WIN*CNT_W-1:0]   win_cnt,
  input  logic [WIN*OP_W-1:0]    win_tag,
  output logic [TAKE_W-1:0]      take_cnt,
  output logic [LANES-1:0]       uop_vld,
  output logic [LANES*OP_W-1:0]  uop_op,
  output logic [LANES*REG_W-1:0] uop_sa,
  output logic [LANES*REG_W-1:0] uop_sb,
  output logic [LANES*REG_W-1:0] uop_dst
);
  localparam logic [CNT_W-1:0] GEN_MAX = CNT_W'(GEN_UOPS);

  logic             seq_act;
  logic [OP_W-1:0]  seq_tag;
  logic [CNT_W-1:0] seq_idx, seq_left;
  logic             seq_start;
  logic [CNT_W-1:0] start_left;
  logic             advance;

  logic [LANES-1:0] lane_vld;
  logic [OP_W-1:0]  lane_tag [LANES];
  logic [CNT_W-1:0] lane_idx [LANES];
  uop_t             lane_uop [LANES];
  logic [WIN-1:0]   grab;
  logic [TAKE_W-1:0] take_d;

  assign advance = !stall && !rst;

  // Steering: program order, general slot first, simple slots chained.
  always_comb begin
    lane_vld   = '0;
    grab       = '0;
    seq_start  = 1'b0;
    start_left = '0;
    take_d     = '0;
    for (int i = 0; i < LANES; i++) begin
      lane_tag[i] = '0;
      lane_idx[i] = '0;
    end
    if (!flush && advance) begin
      if (seq_act) begin
        for (int i = 0; i < GEN_UOPS; i++) begin
          lane_vld[i] = (CNT_W'(i) < seq_left);
          lane_tag[i] = seq_tag;
          lane_idx[i] = seq_idx + CNT_W'(i);
        end
      end else if (win_vld[0]) begin
        grab[0] = 1'b1;
        for (int i = 0; i < GEN_UOPS; i++) begin
          lane_vld[i] = (CNT_W'(i) < win_cnt[0 +: CNT_W]);
          lane_tag[i] = win_tag[0 +: OP_W];
          lane_idx[i] = CNT_W'(i);
        end
        if (win_cnt[0 +: CNT_W] > GEN_MAX) begin
          seq_start  = 1'b1;
          start_left = win_cnt[0 +: CNT_W] - GEN_MAX;
        end else begin
          for (int s = 1; s < WIN; s++) begin
            grab[s] = grab[s-1] && win_vld[s] &&
                      (win_cnt[s*CNT_W +: CNT_W] == CNT_W'(1));
            lane_vld[GEN_UOPS+s-1] = grab[s];
            lane_tag[GEN_UOPS+s-1] = win_tag[s*OP_W +: OP_W];
          end
        end
      end
      for (int s = 0; s < WIN; s++) take_d = take_d + TAKE_W'(grab[s]);
    end
  end

  assign take_cnt = take_d;

  ada_seq #(.CNT_W(CNT_W), .GEN_UOPS(GEN_UOPS)) u_seq (
    .clk(clk), .rst(rst), .flush(flush), .advance(advance),
    .start(seq_start), .start_tag(win_tag[0 +: OP_W]), .start_left(start_left),
    .active(seq_act), .seq_tag(seq_tag), .seq_idx(seq_idx), .seq_left(seq_left)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ada_uop_gen #(.CNT_W(CNT_W)) u_gen (
      .tag(lane_tag[g]), .idx(lane_idx[g]), .uop(lane_uop[g])
    );

    always_ff @(posedge clk) begin
      if (!stall || flush || rst) begin
        uop_op [g*OP_W  +: OP_W]  <= lane_uop[g].op;
        uop_sa [g*REG_W +: REG_W] <= lane_uop[g].src_a;
        uop_sb [g*REG_W +: REG_W] <= lane_uop[g].src_b;
        uop_dst[g*REG_W +: REG_W] <= lane_uop[g].dst;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush)  uop_vld <= '0;
    else if (!stall)   uop_vld <= lane_vld;
  end

  // R7: stalled bundle is held
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    stall && !flush |=> $stable(uop_vld));
  // R8: flush empties the bundle on the next cycle
  assert_flush_clear_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> uop_vld == '0);
  // R5: no new instruction enters while the sequencer owns slot 0
  assert_busy_no_take_R5: assert property (@(posedge clk) disable iff (rst)
    seq_act |-> take_cnt == '0);
  // R3: the second simple slot never fills without the first
  assert_simple_chain_R3: assert property (@(posedge clk) disable iff (rst)
    uop_vld[GEN_UOPS+1] |-> uop_vld[GEN_UOPS]);
  // R4: a simple slot implies the general slot was used
  assert_inorder_R4: assert property (@(posedge clk) disable iff (rst)
    uop_vld[GEN_UOPS] |-> uop_vld[0]);
  // R2: general-slot lanes fill contiguously from lane 0
  assert_lane_contig_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> $onehot0(uop_vld[GEN_UOPS-1:0] ^ (uop_vld[GEN_UOPS-1:0] >> 1)));
endmodule

// File: tb/asym_decode_alloc_test.sv
`timescale 1ns/100ps
module asym_decode_alloc_test;
  logic        clk = 1'b0;
  logic        rst, flush, stall;
  logic [2:0]  win_vld;
  logic [14:0] win_cnt;
  logic [23:0] win_tag;
  logic [1:0]  take_cnt;
  logic [5:0]  uop_vld;
  logic [47:0] uop_op;
  logic [23:0] uop_sa, uop_sb, uop_dst;

  int checks = 0;
  int fails  = 0;

  int         m_left = 0, m_idx = 0;
  logic [7:0] m_tag = 0;
  logic       e_vld [6];
  logic [19:0] e_word [6];

  always #2.5 clk = ~clk;

  asym_decode_alloc uut (
    .clk(clk), .rst(rst), .flush(flush), .stall(stall),
    .win_vld(win_vld), .win_cnt(win_cnt), .win_tag(win_tag),
    .take_cnt(take_cnt), .uop_vld(uop_vld), .uop_op(uop_op),
    .uop_sa(uop_sa), .uop_sb(uop_sb), .uop_dst(uop_dst)
  );

  function automatic logic [19:0] payload(input logic [7:0] t, input int k);
    int op, sa, sb, ds;
    op = (int'(t) + k) % 256;
    sa = (int'(t) ^ k) % 16;
    sb = ((int'(t) >> 4) + k) % 16;
    ds = (int'(t) + 3 * k) % 16;
    return {op[7:0], sa[3:0], sb[3:0], ds[3:0]};
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int c0, input int c1, input int c2,
                      input logic [7:0] t0, input logic [7:0] t1, input logic [7:0] t2,
                      input logic st, input logic fl, input string req);
    int e_take, n;
    logic [2:0] v;
    v = {c2 != 0, c1 != 0, c0 != 0};
    win_vld = v;
    win_cnt = {5'(c2), 5'(c1), 5'(c0)};
    win_tag = {t2, t1, t0};
    stall = st;
    flush = fl;
    e_take = 0;
    if (fl) begin
      for (int i = 0; i < 6; i++) e_vld[i] = 1'b0;
      m_left = 0;
    end else if (!st) begin
      for (int i = 0; i < 6; i++) e_vld[i] = 1'b0;
      if (m_left > 0) begin
        n = (m_left > 4) ? 4 : m_left;
        for (int i = 0; i < n; i++) begin
          e_vld[i] = 1'b1; e_word[i] = payload(m_tag, m_idx + i);
        end
        m_idx += 4;
        m_left -= n;
      end else if (v[0]) begin
        e_take = 1;
        n = (c0 > 4) ? 4 : c0;
        for (int i = 0; i < n; i++) begin
          e_vld[i] = 1'b1; e_word[i] = payload(t0, i);
        end
        if (c0 > 4) begin
          m_left = c0 - 4; m_idx = 4; m_tag = t0;
        end else if (v[1] && c1 == 1) begin
          e_take = 2; e_vld[4] = 1'b1; e_word[4] = payload(t1, 0);
          if (v[2] && c2 == 1) begin
            e_take = 3; e_vld[5] = 1'b1; e_word[5] = payload(t2, 0);
          end
        end
      end
    end
    #1;
    check(take_cnt == 2'(e_take), req, "take count (R9 same cycle)", take_cnt, e_take);
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      check(uop_vld[i] == e_vld[i], req, $sformatf("lane %0d valid", i), uop_vld[i], e_vld[i]);
      if (e_vld[i] && uop_vld[i]) begin
        logic [19:0] w;
        w = {uop_op[i*8 +: 8], uop_sa[i*4 +: 4], uop_sb[i*4 +: 4], uop_dst[i*4 +: 4]};
        check(w == e_word[i], req, $sformatf("lane %0d payload R6", i), w, e_word[i]);
      end
    end
  endtask

  task automatic drain(input int c0, input logic [7:0] t0, input string req);
    while (m_left > 0) step(c0, 0, 0, t0, 8'h00, 8'h00, 1'b0, 1'b0, req);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int opts [6] = '{0, 1, 2, 4, 5, 9};
    rst = 1'b1; flush = 1'b0; stall = 1'b0;
    win_vld = '0; win_cnt = '0; win_tag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(uop_vld == 6'b0, "R1", "reset bundle", uop_vld, 0);
    check(take_cnt == 2'd0, "R1", "reset take", take_cnt, 0);
    @(negedge clk);

    // R2 R3 R4 R5 R6: sweep every count mix over three positions
    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 6; b++)
        for (int c = 0; c < 6; c++) begin
          logic [7:0] t0, t1, t2;
          t0 = 8'(a * 37 + b * 11 + c * 5 + 1);
          t1 = 8'(t0 + 8'h5b);
          t2 = 8'(t0 + 8'hc3);
          step(opts[a], opts[b], opts[c], t0, t1, t2, 1'b0, 1'b0, "R2/R3/R4/R5");
          drain(opts[a], t0, "R5 sequencer");
          step(0, 0, 0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R4 empty");
        end

    // R7: stall mid-sequence, then resume
    step(13, 1, 1, 8'h9e, 8'h01, 8'h02, 1'b0, 1'b0, "R5 start");
    step(13, 1, 1, 8'h9e, 8'h01, 8'h02, 1'b0, 1'b0, "R5 step");
    step(13, 1, 1, 8'h9e, 8'h01, 8'h02, 1'b1, 1'b0, "R7 stall");
    step(13, 1, 1, 8'h9e, 8'h01, 8'h02, 1'b1, 1'b0, "R7 stall");
    drain(13, 8'h9e, "R7 resume");
    step(1, 1, 1, 8'h44, 8'h45, 8'h46, 1'b1, 1'b0, "R7 stall idle");
    step(1, 1, 1, 8'h44, 8'h45, 8'h46, 1'b0, 1'b0, "R3 after stall");

    // R8: flush abandons sequencing and beats stall
    step(11, 0, 0, 8'h7d, 8'h00, 8'h00, 1'b0, 1'b0, "R5 start");
    step(11, 0, 0, 8'h7d, 8'h00, 8'h00, 1'b1, 1'b1, "R8 flush over stall");
    step(1, 1, 1, 8'hb0, 8'hb1, 8'hb2, 1'b0, 1'b0, "R8 after flush");
    step(2, 1, 1, 8'hc0, 8'hc1, 8'hc2, 1'b0, 1'b1, "R8 flush window");
    step(4, 1, 2, 8'hd0, 8'hd1, 8'hd2, 1'b0, 1'b0, "R4 stop at pos2");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule